// File: doc/BRIEF.md
# Watchdog Timer with Programmable Reset Pulse

This block is a bus-programmed watchdog. Once software enables it, a down-counter runs from a programmable timeout, and software has to keep reloading it by writing a fixed key to a restart register. If the count reaches zero first, the block responds in one of two ways, chosen by a mode bit.

In direct mode, expiry immediately starts a system reset pulse. In interrupt mode, the first expiry raises an interrupt and reloads the counter. A second expiry that arrives while that interrupt is still pending starts the reset pulse. The pulse length is a 3-bit code giving 2^(code+1) clock cycles. Its reset default is 8 cycles, so software that rewrites the control register with read-modify-write keeps a pulse length that resets the system reliably.

The bus is a single-cycle strobe. Writes take effect at the clock edge. Read data is combinational from the address while a read is requested.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0x08, the count (offset 0x08) reads 0, and both irq_o and sys_rst_o are low.
- R2: The control register has three fields. Bit 0 is the enable, bit 1 is the mode (0 = direct reset, 1 = interrupt first), and bits [4:2] are the pulse code. Every written field reads back unchanged, except the enable: once it is 1, writing 0 to it leaves it at 1 until reset.
- R3: The timeout register at offset 0x04 holds two codes: the running code n in bits [3:0] and the initial code m in bits [7:4], and it reads back as written. The count follows a fixed sequence:
  - The edge that sets the enable loads 2^(BASE+m)-1 into the count.
  - The count then falls by one per cycle.
  - A cycle in which the count is 0 is an expiry, and the following edge loads 2^(BASE+n)-1.
  - The current count reads at offset 0x08.
- R4: While enabled, a write to offset 0x0C whose low byte is 0x76 loads 2^(BASE+n)-1 into the count. A write with any other value has no effect. A restart in the same cycle as a zero count takes precedence, and that cycle is not an expiry.
- R5: A reset trigger drives sys_rst_o high for exactly 2^(code+1) cycles, using the code held at the trigger edge. A trigger that arrives while a pulse is active is ignored. In direct mode, every expiry is a trigger.
- R6: In interrupt mode, an expiry with irq_o low sets irq_o. An expiry with irq_o high is a reset trigger, and irq_o stays high.
- R7: A read of offset 0x14 clears irq_o. If that read falls in the same cycle as an interrupt-mode expiry, the clear acts first: irq_o stays set and no reset is triggered.
- R8: While disabled, the count holds its value, irq_o and sys_rst_o stay low, and restart writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while req_i is high and we_i is low |
| irq_o | output | 1 | Watchdog interrupt |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
Two same-cycle collisions are provoked. In the first, the bench follows its model's count and issues the restart write in exactly the cycle the count is zero; the restart must win, so no interrupt rises. In the second, with an interrupt already pending, the bench issues the clear read in an expiry cycle; the interrupt must stay set and no reset pulse may start. The model also lets expiries arrive during a long pulse, and those expiries must not extend or restart it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFF_CTRL    = 8'h00;
  localparam logic [7:0] OFF_TORR    = 8'h04;
  localparam logic [7:0] OFF_COUNT   = 8'h08;
  localparam logic [7:0] OFF_RESTART = 8'h0C;
  localparam logic [7:0] OFF_CLR     = 8'h14;
  localparam logic [7:0] RESTART_KEY = 8'h76;

  typedef struct packed {
    logic [2:0] code;
    logic       mode;  // 1: interrupt first
    logic       en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{code: 3'b010, mode: 1'b0, en: 1'b0};
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output ctrl_t       ctrl_o,
  output logic [3:0]  top_o,
  output logic [3:0]  init_o,
  output logic        en_set_o,
  output logic        restart_o,
  output logic        clr_o
);
  ctrl_t      ctrl_q;
  logic [3:0] top_q, init_q;
  logic       wr, wr_ctrl, wr_torr;

  assign wr      = req_i & we_i;
  assign wr_ctrl = wr && addr_i == OFF_CTRL;
  assign wr_torr = wr && addr_i == OFF_TORR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      top_q  <= '0;
      init_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en   <= ctrl_q.en | wdata_i[0];  // sticky until reset
        ctrl_q.mode <= wdata_i[1];
        ctrl_q.code <= wdata_i[4:2];
      end
      if (wr_torr) begin
        top_q  <= wdata_i[3:0];
        init_q <= wdata_i[7:4];
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign top_o     = top_q;
  assign init_o    = init_q;
  assign en_set_o  = wr_ctrl & wdata_i[0] & ~ctrl_q.en;
  assign restart_o = wr && addr_i == OFF_RESTART && wdata_i[7:0] == RESTART_KEY && ctrl_q.en;
  assign clr_o     = req_i && !we_i && addr_i == OFF_CLR;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 32,
  parameter int BASE  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             en_set_i,
  input  logic             restart_i,
  input  logic [3:0]       top_i,
  input  logic [3:0]       init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONES = '1;

  function automatic logic [CNT_W-1:0] period_ld(input logic [3:0] n);
    return ONES >> (CNT_W - BASE - int'(n));
  endfunction

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = en_i & ~restart_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (en_set_i)               cnt_q <= period_ld(init_i);
    else if (en_i) begin
      if (restart_i || cnt_q == '0)  cnt_q <= period_ld(top_i);
      else                           cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o
);
  localparam int PCNT_W = (1 << CODE_W) + 1;
  localparam logic [PCNT_W-1:0] ONES = '1;

  logic [PCNT_W-1:0] pcnt_q;
  logic              act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pcnt_q <= '0;
    end else if (act_q) begin
      if (pcnt_q == '0) act_q <= 1'b0;
      else              pcnt_q <= pcnt_q - 1'b1;
    end else if (trig_i) begin
      act_q  <= 1'b1;
      pcnt_q <= ONES >> (PCNT_W - 1 - int'(code_i));  // 2^(code+1)-1
    end
  end

  assign pulse_o = act_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BASE  = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        sys_rst_o
);
  ctrl_t            ctrl;
  logic [3:0]       top, init;
  logic             en_set, restart, clr, expire, trig, irq_q;
  logic [CNT_W-1:0] cnt;

  wdog_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .ctrl_o(ctrl), .top_o(top), .init_o(init),
    .en_set_o(en_set), .restart_o(restart), .clr_o(clr)
  );

  wdog_count #(.CNT_W(CNT_W), .BASE(BASE)) u_count (
    .clk_i, .rst_ni, .en_i(ctrl.en), .en_set_i(en_set), .restart_i(restart),
    .top_i(top), .init_i(init), .cnt_o(cnt), .expire_o(expire)
  );

  // clear acts before a coincident expiry
  assign trig = expire & (~ctrl.mode | (irq_q & ~clr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   irq_q <= 1'b0;
    else if (expire && ctrl.mode)  irq_q <= 1'b1;
    else if (clr)                  irq_q <= 1'b0;
  end

  wdog_pulse #(.CODE_W(3)) u_pulse (
    .clk_i, .rst_ni, .trig_i(trig), .code_i(ctrl.code), .pulse_o(sys_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        OFF_CTRL:  rdata_o = {27'd0, ctrl};
        OFF_TORR:  rdata_o = {24'd0, init, top};
        OFF_COUNT: rdata_o = 32'(cnt);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             en_set_i,
  input logic             restart_i,
  input logic             clr_i,
  input logic             expire_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             irq_i,
  input logic             rst_pulse_i
);
  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> en_i);                                              // R2
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!irq_i && !rst_pulse_i));                         // R8
  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !en_set_i) |=> $stable(cnt_i));                    // R8
  AST_RESTART_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !$rose(irq_i));                                // R4
  AST_CLR_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !expire_i) |=> !irq_i);                            // R7
  AST_EXP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> cnt_i != '0);                                   // R3
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctrl.en), .en_set_i(en_set),
  .restart_i(restart), .clr_i(clr), .expire_i(expire), .cnt_i(cnt),
  .irq_i(irq_o), .rst_pulse_i(sys_rst_o)
);

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
  localparam int BASE = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sys_rst;

  int n_chk = 0, n_err = 0, cyc = 0;

  // reference model state
  int m_en = 0, m_mode = 0, m_code = 2, m_top = 0, m_init = 0, m_irq = 0, m_prem = 0;
  longint m_cnt = 0;

  always #2.5 clk = ~clk;

  wdog_timer #(.CNT_W(32), .BASE(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(sys_rst)
  );

  function automatic longint per(int n);
    return (longint'(1) << (BASE + n)) - 1;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // model update at each edge, then per-cycle output comparison
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      bit wr, rs, cl, ex, tg;
      int code_old;
      wr = req && we;
      rs = wr && addr == 8'h0C && wdata[7:0] == 8'h76 && m_en == 1;
      cl = req && !we && addr == 8'h14;
      ex = m_en == 1 && !rs && m_cnt == 0;
      code_old = m_code;
      tg = 0;
      if (wr && addr == 8'h00 && wdata[0] && m_en == 0) m_cnt = per(m_init);
      else if (m_en == 1) begin
        if (rs || m_cnt == 0) m_cnt = per(m_top);
        else m_cnt = m_cnt - 1;
      end
      if (ex && m_mode == 1) begin
        if (m_irq == 1 && !cl) tg = 1;
        m_irq = 1;
      end else begin
        if (ex) tg = 1;
        if (cl) m_irq = 0;
      end
      if (m_prem > 0) m_prem--;
      else if (tg) m_prem = 1 << (code_old + 1);
      if (wr && addr == 8'h00) begin
        if (wdata[0]) m_en = 1;
        m_mode = int'(wdata[1]);
        m_code = int'(wdata[4:2]);
      end
      if (wr && addr == 8'h04) begin
        m_top  = int'(wdata[3:0]);
        m_init = int'(wdata[7:4]);
      end
      #1;
      check("R6 irq_o per cycle", longint'(irq), longint'(m_irq));
      check("R5 sys_rst_o per cycle", longint'(sys_rst), longint'(m_prem > 0));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, string tag, longint exp);
    req = 1; we = 0; addr = a;
    #1;
    check(tag, longint'(rdata), exp);
    @(negedge clk);
    req = 0;
  endtask

  task automatic rd_cnt(string tag);
    longint e;
    e = m_cnt;
    rd(8'h08, tag, e);
  endtask

  task automatic wait_zero();
    int g = 0;
    while (m_cnt != 0 && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic measure(string tag, int exp);
    int n = 0, g = 0;
    @(posedge clk); #1;
    while (!sys_rst && g < 5000) begin @(posedge clk); #1; g++; end
    while (sys_rst && n < 5000) begin n++; @(posedge clk); #1; end
    check(tag, n, exp);
    @(negedge clk);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, "R1 ctrl reset", 64'h08);
    rd(8'h08, "R1 count reset", 0);
    check("R1 outputs low", longint'({irq, sys_rst}), 0);

    repeat (20) @(negedge clk);
    wr(8'h0C, 32'h76);
    rd(8'h08, "R8 count held while disabled", 0);
    check("R8 outputs quiet", longint'({irq, sys_rst}), 0);

    wr(8'h04, 32'h10);                      // init 1, run 0
    rd(8'h04, "R3 timeout readback", 64'h10);
    wr(8'h00, 32'h0B);                      // en, irq mode, code 2
    rd(8'h00, "R2 ctrl readback", 64'h0B);
    rd_cnt("R3 count after enable");
    repeat (5) @(negedge clk);
    rd_cnt("R3 count running");

    repeat (40) @(negedge clk);
    check("R6 first expiry raises irq", longint'(irq), 1);
    rd(8'h14, "R7 clear read data", 0);
    check("R7 irq cleared", longint'(irq), 0);

    for (int i = 0; i < 8; i++) begin
      repeat (8) @(negedge clk);
      wr(8'h0C, 32'h76);
    end
    check("R4 restarts keep irq low", longint'(irq), 0);
    rd_cnt("R4 count after restart");

    for (int i = 0; i < 3; i++) begin
      repeat (6) @(negedge clk);
      wr(8'h0C, 32'h75);
    end
    repeat (4) @(negedge clk);
    check("R4 wrong key ignored, irq raised", longint'(irq), 1);
    measure("R6 second expiry pulse length 8", 8);

    rd(8'h14, "R7 clear read data", 0);
    wr(8'h00, 32'h0A);
    rd(8'h00, "R2 enable sticky", 64'h0B);

    wait_zero();
    wr(8'h0C, 32'h76);
    @(negedge clk);
    check("R4 restart at zero wins", longint'(irq), 0);

    repeat (20) @(negedge clk);
    check("R6 irq set before collision", longint'(irq), 1);
    wait_zero();
    rd(8'h14, "R7 clear in expiry cycle data", 0);
    check("R7 irq stays set on collision", longint'(irq), 1);
    check("R7 no pulse on collision", longint'(sys_rst), 0);

    rd(8'h14, "R7 clear", 0);
    wr(8'h00, 32'h01);                      // direct mode, code 0
    measure("R5 pulse length code 0", 2);
    wr(8'h00, 32'h1D);                      // direct mode, code 7
    measure("R5 pulse code 7 with expiries during pulse", 256);
    measure("R5 next pulse code 7", 256);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule